// File: doc/BRIEF.md
# Four-Channel DMA Register File

This block models the register file of a classic four-channel DMA controller as software sees it over an 8-bit I/O port bus. A port write or read selects one of sixteen register slots. Eight slots reach the per-channel 16-bit address and count registers, one byte at a time. The other eight slots are control actions: command, request, single mask, mode, byte-pointer clear, master clear, clear all masks and write all masks. A separate page space holds one 8-bit page register per channel.

Each channel keeps a base address, a base count, a current (start) address and a count of units already transferred. A per-channel step strobe stands in for one completed bus transfer. On a channel that is allowed to run, the strobe advances the transferred count. When the count passes the programmed base count, the strobe raises that channel's terminal-count flag. The parameter `SHIFT` selects the byte-wide instance (0) or the word-wide instance (1). The word-wide instance drops the lowest port address bit before decoding and scales addresses and counts by two.

Top module: `dma4_regs`

## Requirements
- R1: After reset, all four mask bits are set and the command, status, byte pointer, mode, page and channel registers are zero.
- R2: The slot index is `(io_addr >> SHIFT) & 0xF`. For slots 0 to 7, the channel is `index >> 1`, and index bit 0 selects address (0) or count (1).
- R3: Each read or write of a channel slot toggles the shared byte pointer after the access. A write with the pointer clear loads the low byte. A write with the pointer set loads the high byte and restarts the channel: current address becomes base address shifted left by `SHIFT`, and transferred count becomes 0.
- R4: An address read returns `(current + dir*transferred) >> (SHIFT + 8*pointer)`, low 8 bits. Here dir is -1 when bit 5 of the channel mode is set, and +1 otherwise.
- R5: A count read returns `((base_count << SHIFT) - transferred) >> (SHIFT + 8*pointer)`, low 8 bits.
- R6: A write to slot 8 stores the command only if every data bit other than bit 2 is zero. When stored, command bit 2 halts all channel steps.
- R7: A write to slot 9 sets status bit `4+data[1:0]` to data bit 2 and clears status bit `data[1:0]`.
- R8: Slot 10 sets the mask of channel `data[1:0]` to data bit 2. Slot 14 clears all masks. Slot 15 loads the masks from `data[3:0]`.
- R9: Slot 12 clears the byte pointer. Slot 13 clears the byte pointer, command and status, and sets all masks. Slot 11 stores the whole data byte as the mode of channel `data[1:0]`.
- R10: A read of slot 8 returns the status byte and clears status bits 3:0 at that clock edge.
- R11: Page writes at page offsets 1, 2, 3 and 7 load the page of channels 2, 3, 1 and 0. Writes at any other offset change nothing.
- R12: A step strobe on a channel that is unmasked, has no terminal-count flag and is not halted adds `1 << SHIFT` to the transferred count. If the new count exceeds `base_count << SHIFT`, the step sets status bit `channel`. Otherwise the step has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset (master clear) |
| io_wr | input | 1 | Port write strobe, one cycle per access |
| io_rd | input | 1 | Port read strobe; side effects at the closing edge |
| io_page | input | 1 | 1 selects page register space, 0 the main slots |
| io_addr | input | 5 | Port address |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational from address and state |
| xfer_step | input | 4 | Per-channel transfer-step strobe |
| cmd_o | output | 8 | Command register |
| mask_o | output | 4 | Channel mask bits |
| page_o | output | 32 | Page registers, channel n at bits 8n+7:8n |

## Verification
Read data is combinational. It is due in the same cycle as the read strobe, and the bench samples it 1 ns after the falling edge that presents the address. Writes, steps and read side effects (byte pointer toggle, status clear) take effect at the next rising edge. So every later access and every look at `cmd_o`, `mask_o` and `page_o` waits for the following falling edge. The bench updates its reference model only after that edge. Each expected value therefore reflects exactly the accesses that the design has already clocked in.

// File: rtl/dma4_regs.sv
module dma4_regs #(
  parameter int SHIFT = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic        io_page,
  input  logic [4:0]  io_addr,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  input  logic [3:0]  xfer_step,
  output logic [7:0]  cmd_o,
  output logic [3:0]  mask_o,
  output logic [31:0] page_o
);
  localparam int CW = 18;
  localparam logic [CW-1:0] UNIT = CW'(1) << SHIFT;

  logic [15:0]   base_a [4];
  logic [15:0]   base_c [4];
  logic [CW-1:0] cur_a  [4];
  logic [CW-1:0] cnt    [4];
  logic [CW-1:0] nxt    [4];
  logic [7:0]    mode   [4];
  logic [7:0]    page   [4];
  logic [7:0]    status, st_nx, cmd;
  logic [3:0]    mask, go;
  logic          ff;

  logic [3:0] idx;
  logic [1:0] ch, dch;
  logic       acc_ch, wr_ch, wr_ctl;
  assign idx    = 4'(io_addr >> SHIFT);
  assign ch     = idx[2:1];
  assign dch    = io_wdata[1:0];
  assign acc_ch = (io_wr || io_rd) && !io_page && !idx[3];
  assign wr_ch  = io_wr && !io_page && !idx[3];
  assign wr_ctl = io_wr && !io_page && idx[3];

  assign cmd_o  = cmd;
  assign mask_o = mask;
  assign page_o = {page[3], page[2], page[1], page[0]};

  always_comb begin
    logic [CW-1:0] v;
    if (idx[0])            v = ({2'b0, base_c[ch]} << SHIFT) - cnt[ch];
    else if (mode[ch][5])  v = cur_a[ch] - cnt[ch];
    else                   v = cur_a[ch] + cnt[ch];
    v = v >> (SHIFT + (ff ? 8 : 0));
    if (io_page)            io_rdata = '0;
    else if (idx == 4'h8)   io_rdata = status;
    else if (idx[3])        io_rdata = '0;
    else                    io_rdata = v[7:0];
  end

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      go[i]  = xfer_step[i] && !mask[i] && !status[i] && !cmd[2];
      nxt[i] = cnt[i] + UNIT;
    end
    st_nx = status;
    if (io_rd && !io_page && idx == 4'h8) st_nx[3:0] = 4'h0;
    if (wr_ctl && idx == 4'h9) begin
      st_nx[{1'b1, dch}] = io_wdata[2];
      st_nx[{1'b0, dch}] = 1'b0;
    end
    if (wr_ctl && idx == 4'hD) st_nx = '0;
    for (int i = 0; i < 4; i++)
      if (go[i] && nxt[i] > ({2'b0, base_c[i]} << SHIFT)) st_nx[i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        base_a[i] <= '0; base_c[i] <= '0; cur_a[i] <= '0;
        cnt[i] <= '0; mode[i] <= '0; page[i] <= '0;
      end
      status <= '0; cmd <= '0; mask <= 4'hF; ff <= 1'b0;
    end else begin
      status <= st_nx;
      for (int i = 0; i < 4; i++)
        if (go[i]) cnt[i] <= nxt[i];
      if (acc_ch) ff <= !ff;
      if (wr_ch) begin
        if (!ff) begin
          if (idx[0]) base_c[ch][7:0] <= io_wdata;
          else        base_a[ch][7:0] <= io_wdata;
        end else begin
          if (idx[0]) base_c[ch][15:8] <= io_wdata;
          else        base_a[ch][15:8] <= io_wdata;
          cur_a[ch] <= {2'b0, idx[0] ? base_a[ch] : {io_wdata, base_a[ch][7:0]}} << SHIFT;
          cnt[ch]   <= '0;
        end
      end
      if (wr_ctl) begin
        case (idx)
          4'h8: if ((io_wdata & 8'hFB) == 8'h00) cmd <= io_wdata;
          4'hA: mask[dch] <= io_wdata[2];
          4'hB: mode[dch] <= io_wdata;
          4'hC: ff <= 1'b0;
          4'hD: begin ff <= 1'b0; mask <= 4'hF; cmd <= '0; end
          4'hE: mask <= 4'h0;
          4'hF: mask <= io_wdata[3:0];
          default: ;
        endcase
      end
      if (io_wr && io_page) begin
        case (io_addr[2:0])
          3'd1: page[2] <= io_wdata;
          3'd2: page[3] <= io_wdata;
          3'd3: page[1] <= io_wdata;
          3'd7: page[0] <= io_wdata;
          default: ;
        endcase
      end
    end
  end

  assert_ptr_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ch |=> ff != $past(ff));

  assert_cmd_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !io_page && idx == 4'h8 && (io_wdata & 8'hFB) != 8'h00) |=> $stable(cmd_o));

  assert_master_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !io_page && idx == 4'hD && xfer_step == 4'h0)
      |=> (mask_o == 4'hF && cmd_o == 8'h00 && status == 8'h00 && !ff));

  assert_status_rd_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !io_page && idx == 4'h8 && xfer_step == 4'h0) |=> status[3:0] == 4'h0);

  for (genvar g = 0; g < 4; g++) begin : g_chk
    assert_masked_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_step[g] && mask_o[g] && !io_wr) |=> $stable(cnt[g]));
    assert_tc_from_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[g]) |-> ($past(xfer_step[g]) || $past(io_wr)));
  end
endmodule

// File: tb/dma4_regs_bench.sv
`timescale 1ns/1ps
module dma4_regs_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       wr [2], rd [2], pg [2];
  logic [4:0] ad [2];
  logic [7:0] wd [2], rdt [2], cmdo [2];
  logic [3:0] st [2], msk [2];
  logic [31:0] pgo [2];

  dma4_regs #(.SHIFT(0)) u_dma4_regs (
    .clk(clk), .rst_n(rst_n), .io_wr(wr[0]), .io_rd(rd[0]), .io_page(pg[0]),
    .io_addr(ad[0]), .io_wdata(wd[0]), .io_rdata(rdt[0]), .xfer_step(st[0]),
    .cmd_o(cmdo[0]), .mask_o(msk[0]), .page_o(pgo[0]));

  dma4_regs #(.SHIFT(1)) u_dma4_regs_w (
    .clk(clk), .rst_n(rst_n), .io_wr(wr[1]), .io_rd(rd[1]), .io_page(pg[1]),
    .io_addr(ad[1]), .io_wdata(wd[1]), .io_rdata(rdt[1]), .xfer_step(st[1]),
    .cmd_o(cmdo[1]), .mask_o(msk[1]), .page_o(pgo[1]));

  int checks = 0, fails = 0;
  bit done = 0;

  logic [15:0] mba [2][4], mbc [2][4];
  logic [17:0] mcur [2][4], mcnt [2][4];
  logic [7:0]  mmode [2][4], mpage [2][4], mstat [2], mcmd [2];
  logic [3:0]  mmask [2];
  bit          mff [2];

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic model_reset(int d);
    for (int c = 0; c < 4; c++) begin
      mba[d][c] = 0; mbc[d][c] = 0; mcur[d][c] = 0; mcnt[d][c] = 0;
      mmode[d][c] = 0; mpage[d][c] = 0;
    end
    mstat[d] = 0; mcmd[d] = 0; mmask[d] = 4'hF; mff[d] = 0;
  endtask

  function automatic logic [4:0] mk_addr(int d, logic [3:0] idx, logic junk);
    return (d == 0) ? {junk, idx} : {idx, junk};
  endfunction

  function automatic logic [7:0] exp_chan(int d, logic [3:0] idx);
    int c = int'(idx[2:1]);
    logic [17:0] v;
    if (idx[0]) v = (18'(mbc[d][c]) << d) - mcnt[d][c];
    else if (mmode[d][c][5]) v = mcur[d][c] - mcnt[d][c];
    else v = mcur[d][c] + mcnt[d][c];
    v = v >> (d + (mff[d] ? 8 : 0));
    return v[7:0];
  endfunction

  task automatic model_wr(int d, logic [3:0] idx, logic [7:0] v);
    int c = int'(idx[2:1]);
    int t = int'(v[1:0]);
    if (!idx[3]) begin
      if (!mff[d]) begin
        if (idx[0]) mbc[d][c][7:0] = v; else mba[d][c][7:0] = v;
      end else begin
        if (idx[0]) mbc[d][c][15:8] = v; else mba[d][c][15:8] = v;
        mcur[d][c] = 18'(mba[d][c]) << d;
        mcnt[d][c] = 0;
      end
      mff[d] = !mff[d];
    end else begin
      case (idx)
        4'h8: if (v == 0 || v == 8'h04) mcmd[d] = v;
        4'h9: begin mstat[d][t+4] = v[2]; mstat[d][t] = 1'b0; end
        4'hA: mmask[d][t] = v[2];
        4'hB: mmode[d][t] = v;
        4'hC: mff[d] = 0;
        4'hD: begin mff[d] = 0; mmask[d] = 4'hF; mstat[d] = 0; mcmd[d] = 0; end
        4'hE: mmask[d] = 0;
        default: mmask[d] = v[3:0];
      endcase
    end
  endtask

  task automatic do_wr(int d, logic [3:0] idx, logic [7:0] v);
    @(negedge clk);
    pg[d] = 0; ad[d] = mk_addr(d, idx, 1'($urandom)); wd[d] = v; wr[d] = 1;
    @(negedge clk);
    wr[d] = 0;
    model_wr(d, idx, v);
  endtask

  task automatic do_page(int d, logic [2:0] off, logic [7:0] v);
    @(negedge clk);
    pg[d] = 1; ad[d] = {2'b00, off}; wd[d] = v; wr[d] = 1;
    @(negedge clk);
    wr[d] = 0; pg[d] = 0;
    case (off)
      3'd1: mpage[d][2] = v;
      3'd2: mpage[d][3] = v;
      3'd3: mpage[d][1] = v;
      3'd7: mpage[d][0] = v;
      default: ;
    endcase
  endtask

  task automatic do_rd(int d, logic [3:0] idx, output logic [7:0] got);
    @(negedge clk);
    pg[d] = 0; ad[d] = mk_addr(d, idx, 1'($urandom)); rd[d] = 1;
    #1 got = rdt[d];
    @(negedge clk);
    rd[d] = 0;
  endtask

  task automatic rd_chan(int d, logic [3:0] idx, string tag);
    logic [7:0] g, e;
    e = exp_chan(d, idx);
    do_rd(d, idx, g);
    chk(tag, int'(g), int'(e));
    mff[d] = !mff[d];
  endtask

  task automatic rd_stat(int d, string tag);
    logic [7:0] g;
    do_rd(d, 4'h8, g);
    chk(tag, int'(g), int'(mstat[d]));
    mstat[d][3:0] = 0;
  endtask

  task automatic do_step(int d, int c);
    @(negedge clk);
    st[d] = 4'(1 << c);
    @(negedge clk);
    st[d] = 0;
    if (!mmask[d][c] && !mstat[d][c] && !mcmd[d][2]) begin
      mcnt[d][c] = mcnt[d][c] + (18'd1 << d);
      if (mcnt[d][c] > (18'(mbc[d][c]) << d)) mstat[d][c] = 1'b1;
    end
  endtask

  task automatic chk_outs(int d);
    chk("R6 cmd", int'(cmdo[d]), int'(mcmd[d]));
    chk("R8 mask", int'(msk[d]), int'(mmask[d]));
    chk("R11 page", int'(pgo[d]), int'({mpage[d][3], mpage[d][2], mpage[d][1], mpage[d][0]}));
  endtask

  task automatic rand_ops(int d, int n);
    for (int k = 0; k < n; k++) begin
      int r = int'($urandom % 10);
      case (r)
        0, 1, 2: do_wr(d, 4'($urandom % 8), 8'($urandom));
        3: begin
          logic [3:0] ix = 4'(8 + $urandom % 8);
          logic [7:0] v = 8'($urandom);
          if (ix == 4'h8) v = ($urandom % 2) ? 8'h00 : v;
          if (ix == 4'hD && ($urandom % 4) != 0) ix = 4'hE;
          do_wr(d, ix, v);
        end
        4: do_page(d, 3'($urandom), 8'($urandom));
        5, 6: begin
          logic [3:0] ix = 4'($urandom % 8);
          rd_chan(d, ix, ix[0] ? "R5 count read" : "R4 address read");
        end
        7: rd_stat(d, "R7 status");
        default: do_step(d, int'($urandom % 4));
      endcase
      if (k % 16 == 0) chk_outs(d);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] g;
    void'($urandom(32'd20240611));
    for (int d = 0; d < 2; d++) begin
      wr[d] = 0; rd[d] = 0; pg[d] = 0; ad[d] = 0; wd[d] = 0; st[d] = 0;
      model_reset(d);
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 mask", int'(msk[0]), 'hF);
    chk("R1 cmd", int'(cmdo[0]), 0);
    chk("R1 page", int'(pgo[0]), 0);
    rd_stat(0, "R1 status");

    // R3 R4: program channel 1 address 0x1234, count 2, mode up
    do_wr(0, 4'hC, 0);
    do_wr(0, 4'h2, 8'h34); do_wr(0, 4'h2, 8'h12);
    do_wr(0, 4'h3, 8'h02); do_wr(0, 4'h3, 8'h00);
    do_wr(0, 4'hB, 8'h01);
    do_wr(0, 4'hA, 8'h01);
    do_rd(0, 4'h2, g); chk("R3 low byte first", int'(g), 'h34); mff[0] = !mff[0];
    do_rd(0, 4'h2, g); chk("R3 high byte second", int'(g), 'h12); mff[0] = !mff[0];

    // R12 terminal count after base+1 steps
    do_step(0, 1); do_step(0, 1);
    do_rd(0, 4'h8, g); chk("R12 no tc yet", int'(g), 'h00); mstat[0][3:0] = 0;
    do_step(0, 1);
    do_rd(0, 4'h8, g); chk("R12 tc set", int'(g), 'h02); mstat[0][3:0] = 0;
    do_rd(0, 4'h8, g); chk("R10 tc cleared by read", int'(g), 'h00);
    do_rd(0, 4'h3, g); chk("R5 count low", int'(g), 'hFF); mff[0] = !mff[0];
    do_rd(0, 4'h2, g); chk("R4 address high after steps", int'(g), 'h12); mff[0] = !mff[0];
    do_wr(0, 4'hC, 0);
    do_rd(0, 4'h2, g); chk("R4 address low after steps", int'(g), 'h37); mff[0] = !mff[0];
    do_wr(0, 4'hC, 0);

    // R4 down direction
    do_wr(0, 4'hB, 8'h21);
    do_rd(0, 4'h2, g); chk("R4 down address", int'(g), 'h31); mff[0] = !mff[0];
    do_wr(0, 4'hC, 0);

    // R6 command reject and halt
    do_wr(0, 4'h8, 8'h05); chk("R6 reject", int'(cmdo[0]), 0);
    do_wr(0, 4'h8, 8'h04); chk("R6 accept", int'(cmdo[0]), 4);
    do_wr(0, 4'h2, 8'h00); do_wr(0, 4'h2, 8'h10);
    do_wr(0, 4'hB, 8'h01);
    do_step(0, 1);
    do_wr(0, 4'hC, 0);
    do_rd(0, 4'h2, g); chk("R6 halted step", int'(g), 'h00); mff[0] = !mff[0];
    do_wr(0, 4'h8, 8'h00);

    // R7 request bits
    do_wr(0, 4'h9, 8'h06);
    do_rd(0, 4'h8, g); chk("R7 request set", int'(g), 'h40); mstat[0][3:0] = 0;
    do_wr(0, 4'h9, 8'h02);
    rd_stat(0, "R7 request clear");

    // R8 masks
    do_wr(0, 4'hF, 8'hA5); chk("R8 write all", int'(msk[0]), 5);
    do_wr(0, 4'hA, 8'h04); chk("R8 single set", int'(msk[0]), 5);
    do_wr(0, 4'hA, 8'h02); chk("R8 single clear", int'(msk[0]), 1);
    do_wr(0, 4'hE, 8'hFF); chk("R8 clear all", int'(msk[0]), 0);

    // R11 page mapping and ignored offsets
    do_page(0, 3'd7, 8'hA0); do_page(0, 3'd3, 8'hA1);
    do_page(0, 3'd1, 8'hA2); do_page(0, 3'd2, 8'hA3);
    chk("R11 map", int'(pgo[0]), 'hA3A2A1A0);
    do_page(0, 3'd0, 8'h55); do_page(0, 3'd4, 8'h55);
    do_page(0, 3'd5, 8'h55); do_page(0, 3'd6, 8'h55);
    chk("R11 ignored offsets", int'(pgo[0]), 'hA3A2A1A0);

    // R9 master clear
    do_wr(0, 4'h8, 8'h04); do_wr(0, 4'h2, 8'h77);
    do_wr(0, 4'hD, 8'h00);
    chk("R9 mask set", int'(msk[0]), 'hF);
    chk("R9 cmd zero", int'(cmdo[0]), 0);
    do_rd(0, 4'h2, g); chk("R9 pointer cleared", int'(g), int'(exp_chan(0, 4'h2))); mff[0] = !mff[0];

    // R2 word instance: address 0x0010 words, step 2 bytes
    do_wr(1, 4'h2, 8'h10); do_wr(1, 4'h2, 8'h00);
    do_wr(1, 4'h3, 8'h05); do_wr(1, 4'h3, 8'h00);
    do_wr(1, 4'hE, 8'h00);
    do_rd(1, 4'h2, g); chk("R2 word address", int'(g), 'h10); mff[1] = !mff[1];
    do_wr(1, 4'hC, 0);
    do_step(1, 1);
    do_rd(1, 4'h2, g); chk("R2 word step address", int'(g), 'h11); mff[1] = !mff[1];
    do_wr(1, 4'hC, 0);
    do_rd(1, 4'h3, g); chk("R2 word count", int'(g), 'h04); mff[1] = !mff[1];
    do_wr(1, 4'hC, 0);

    rand_ops(0, 3000);
    rand_ops(1, 1500);
    chk_outs(0);
    chk_outs(1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule